// File: doc/BRIEF.md
# Ring Collective Exchange Engine

This block moves vector blocks among a ring of compute cores between network layers. Every core keeps a local buffer that holds the whole vector, split into one block per core, and core k owns block k. The ring is one-directional. Each core feeds a single registered link into the next core, and every link carries one word per cycle with a valid flag. A word therefore moves exactly one core per clock, and the time to cross the ring grows with the distance between cores.

The engine has two collective operations. In gather mode each core sends its own block and then passes on whatever it receives. When the run ends, every core holds a copy of every owned block. In reduce mode each block starts at the core just after its owner. Every core the block passes through adds its local partial sum for that block, so the final addition lands at the owner. Both modes use the same schedule: NCORES-1 steps of BLK_LEN words each. Their cycle cost is therefore identical.

The host loads and inspects the buffers through a word-wide write port and a combinational read port, and it launches a run with a start/done handshake. The arithmetic that produces the partial sums is outside this block.

Top module: `ring_collective`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: While the engine is idle, a write (`wr_en`, `wr_core`, `wr_addr`, `wr_data`) updates that core's buffer word. The combinational read port then returns the word through `rd_core`/`rd_addr`. Buffer address = block*BLK_LEN + word, and core k owns block k.
- R3: A run started with `mode`=0 (gather) leaves every core's block j equal to block j of core j as it was before the run, for every j.
- R4: A run started with `mode`=1 (reduce) leaves block k of core k equal to the sum, over all cores, of their pre-run block k.
- R5: Reduce addition is 16-bit two's-complement with wraparound.
- R6: `done` is high for exactly one cycle. It is seen on the (NCORES-1)*BLK_LEN+1-th rising edge after the edge that sampled `start` (29 with the defaults). `busy` is high from the start edge until `done` rises, and both modes take the same number of cycles.
- R7: A `start` pulse while `busy` is high is ignored. The run in flight keeps its mode and timing.
- R8: A host write while `busy` is high is ignored and changes no buffer.
- R9: After a reduce run, block j of core k (j != k) holds the partial sum of pre-run block j over cores j+1, j+2, ..., k around the ring.
- R10: A new `start` is accepted in the cycle that `done` is high. The new run operates on the buffers left by the run just completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a run when idle |
| mode | input | 1 | 0 = gather, 1 = reduce; sampled with start |
| busy | output | 1 | Run in progress, including the final link drain |
| done | output | 1 | One-cycle completion pulse |
| wr_en | input | 1 | Host buffer write enable (idle only) |
| wr_core | input | $clog2(NCORES) | Core selected for the host write |
| wr_addr | input | $clog2(NCORES*BLK_LEN) | Buffer word address for the host write |
| wr_data | input | WORD_W | Host write data |
| rd_core | input | $clog2(NCORES) | Core selected for the host read |
| rd_addr | input | $clog2(NCORES*BLK_LEN) | Buffer word address for the host read |
| rd_data | output | WORD_W | Combinational read data |

## Verification
A host write lands at the rising edge that samples it, and the read port is combinational. The bench therefore checks readback a fraction of a nanosecond after setting the read address, while the clock is idle. After the edge that samples `start`, the bench counts rising edges and looks at `done` only at falling edges. `done` must first appear after edge (NCORES-1)*BLK_LEN+1, `busy` must be high at every falling edge before that, and `done` must be low again one edge later. Buffer contents are compared only after `done` has been seen. The reference results come from closed-form gather and ring-partial-sum formulas, not from a step-by-step replay of the schedule.

// File: rtl/ring_pkg.sv
// Shared types and schedule arithmetic for the ring collective engine.
// Assumes ring positions are numbered 0..n-1 in the direction of data flow.
package ring_pkg;

    typedef enum logic {
        MODE_GATHER = 1'b0,
        MODE_REDUCE = 1'b1
    } ring_mode_e;

    // Block index that core `id` transmits during step `step`.
    // Gather: a core starts with its own block. Reduce: it starts with the
    // block owned by its upstream neighbour, so each block ends at its owner.
    function automatic int src_block(int id, int step, int n, logic reduce);
        return (id + 2 * n - step - (reduce ? 1 : 0)) % n;
    endfunction

endpackage

// File: rtl/ring_seq.sv
// Global step/word sequencer shared by all ring nodes.
// Issues (NCORES-1)*BLK_LEN transmit cycles after an accepted start, keeps a
// one-cycle delayed copy of the schedule for the receive side, and pulses
// done when the last received word has been written.
// Assumes NCORES >= 2 and BLK_LEN >= 1.
module ring_seq #(
    parameter int NCORES  = 8,
    parameter int BLK_LEN = 4,
    localparam int SW = (NCORES > 2) ? $clog2(NCORES) : 1,
    localparam int WW = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  ring_pkg::ring_mode_e mode_in,
    output logic                 issue,
    output logic [SW-1:0]        step,
    output logic [WW-1:0]        word,
    output logic                 rx_vld,
    output logic [SW-1:0]        rx_step,
    output logic [WW-1:0]        rx_word,
    output ring_pkg::ring_mode_e mode_q,
    output logic                 busy,
    output logic                 done
);
    localparam int LAST_STEP = NCORES - 2;
    localparam int LAST_WORD = BLK_LEN - 1;

    logic busy_q;
    logic last_tx;
    logic last_rx;

    assign last_tx = (step == SW'(LAST_STEP)) && (word == WW'(LAST_WORD));
    assign last_rx = (rx_step == SW'(LAST_STEP)) && (rx_word == WW'(LAST_WORD));
    assign issue   = busy_q;
    assign busy    = busy_q | rx_vld;

    // Transmit schedule: accept start when fully idle, walk words then steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            step   <= '0;
            word   <= '0;
            mode_q <= ring_pkg::MODE_GATHER;
        end else if (!busy_q) begin
            if (start && !rx_vld) begin
                busy_q <= 1'b1;
                step   <= '0;
                word   <= '0;
                mode_q <= mode_in;
            end
        end else if (word == WW'(LAST_WORD)) begin
            word <= '0;
            if (last_tx) begin
                busy_q <= 1'b0;
            end else begin
                step <= step + 1'b1;
            end
        end else begin
            word <= word + 1'b1;
        end
    end

    // Receive schedule: the transmit schedule delayed by one link register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_vld  <= 1'b0;
            rx_step <= '0;
            rx_word <= '0;
            done    <= 1'b0;
        end else begin
            rx_vld  <= busy_q;
            rx_step <= step;
            rx_word <= word;
            done    <= rx_vld && last_rx;
        end
    end

    a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |=> done);

    a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(mode_q));

    a_r6_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (step <= SW'(LAST_STEP)));

endmodule

// File: rtl/ring_node.sv
// One ring position: the core's local vector buffer, its transmit selection
// and the outgoing link register. A received word is written (gather) or
// added to the local word (reduce) at the block address the upstream core
// sent. A read that hits the word being written this cycle is bypassed.
// Host writes are accepted only when the top has qualified them as idle.
module ring_node #(
    parameter int NCORES  = 8,
    parameter int BLK_LEN = 4,
    parameter int WORD_W  = 16,
    parameter int CORE_ID = 0,
    localparam int DEPTH = NCORES * BLK_LEN,
    localparam int AW = $clog2(DEPTH),
    localparam int SW = (NCORES > 2) ? $clog2(NCORES) : 1,
    localparam int WW = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ring_pkg::ring_mode_e mode,
    input  logic                 issue,
    input  logic [SW-1:0]        step,
    input  logic [WW-1:0]        word,
    input  logic                 rx_vld,
    input  logic [SW-1:0]        rx_step,
    input  logic [WW-1:0]        rx_word,
    input  logic                 link_in_vld,
    input  logic [WORD_W-1:0]    link_in_data,
    input  logic                 host_we,
    input  logic [AW-1:0]        host_addr,
    input  logic [WORD_W-1:0]    host_data,
    input  logic [AW-1:0]        rd_addr,
    output logic                 link_out_vld,
    output logic [WORD_W-1:0]    link_out_data,
    output logic [WORD_W-1:0]    rd_data
);
    localparam int UPSTREAM = (CORE_ID + NCORES - 1) % NCORES;

    logic [WORD_W-1:0] mem [DEPTH];
    logic              reduce;
    int                send_blk;
    int                rx_blk;
    logic [AW-1:0]     send_addr;
    logic [AW-1:0]     rx_addr;
    logic [WORD_W-1:0] rx_val;
    logic [WORD_W-1:0] send_val;

    assign reduce = (mode == ring_pkg::MODE_REDUCE);

    // Address of the word sent now and of the word arriving now.
    always_comb begin
        send_blk  = ring_pkg::src_block(CORE_ID, int'(step), NCORES, reduce);
        rx_blk    = ring_pkg::src_block(UPSTREAM, int'(rx_step), NCORES, reduce);
        send_addr = AW'(send_blk * BLK_LEN + int'(word));
        rx_addr   = AW'(rx_blk * BLK_LEN + int'(rx_word));
    end

    // Value to store for an arriving word, and the transmit value with bypass.
    always_comb begin
        rx_val   = reduce ? (mem[rx_addr] + link_in_data) : link_in_data;
        send_val = (link_in_vld && (rx_addr == send_addr)) ? rx_val : mem[send_addr];
    end

    // Buffer storage: ring traffic has priority over the host port.
    always_ff @(posedge clk) begin
        if (link_in_vld) begin
            mem[rx_addr] <= rx_val;
        end else if (host_we) begin
            mem[host_addr] <= host_data;
        end
    end

    // Outgoing link register: one word per cycle toward the next core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_out_vld  <= 1'b0;
            link_out_data <= '0;
        end else begin
            link_out_vld  <= issue;
            link_out_data <= issue ? send_val : '0;
        end
    end

    assign rd_data = mem[rd_addr];

    a_r3_link_matches_schedule: assert property (@(posedge clk) disable iff (!rst_n)
        link_in_vld == rx_vld);

    a_r3_issue_reaches_link: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> link_out_vld);

    a_r8_host_excluded: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |-> (!link_in_vld && !issue));

endmodule

// File: rtl/ring_collective.sv
// Top of the ring collective engine: one sequencer and NCORES nodes wired
// into a one-directional ring (node k feeds node k+1, the last feeds node 0).
// Host buffer writes are gated off while a run is active; host reads are
// combinational and always available.
module ring_collective #(
    parameter int NCORES  = 8,
    parameter int BLK_LEN = 4,
    parameter int WORD_W  = 16,
    localparam int CW = $clog2(NCORES),
    localparam int AW = $clog2(NCORES * BLK_LEN),
    localparam int SW = (NCORES > 2) ? $clog2(NCORES) : 1,
    localparam int WW = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    output logic              busy,
    output logic              done,
    input  logic              wr_en,
    input  logic [CW-1:0]     wr_core,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [CW-1:0]     rd_core,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic                 issue;
    logic [SW-1:0]        step;
    logic [WW-1:0]        word;
    logic                 rx_vld;
    logic [SW-1:0]        rx_step;
    logic [WW-1:0]        rx_word;
    ring_pkg::ring_mode_e mode_q;

    logic [NCORES-1:0]    link_vld;
    logic [WORD_W-1:0]    link_data [NCORES];
    logic [WORD_W-1:0]    node_rd   [NCORES];

    ring_seq #(
        .NCORES  (NCORES),
        .BLK_LEN (BLK_LEN)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mode_in (ring_pkg::ring_mode_e'(mode)),
        .issue   (issue),
        .step    (step),
        .word    (word),
        .rx_vld  (rx_vld),
        .rx_step (rx_step),
        .rx_word (rx_word),
        .mode_q  (mode_q),
        .busy    (busy),
        .done    (done)
    );

    for (genvar k = 0; k < NCORES; k++) begin : g_node
        localparam int PREV = (k + NCORES - 1) % NCORES;
        logic host_we;

        // Host write for this core, blocked while ring traffic is pending.
        assign host_we = wr_en && !busy && (wr_core == CW'(k));

        ring_node #(
            .NCORES  (NCORES),
            .BLK_LEN (BLK_LEN),
            .WORD_W  (WORD_W),
            .CORE_ID (k)
        ) i_node (
            .clk           (clk),
            .rst_n         (rst_n),
            .mode          (mode_q),
            .issue         (issue),
            .step          (step),
            .word          (word),
            .rx_vld        (rx_vld),
            .rx_step       (rx_step),
            .rx_word       (rx_word),
            .link_in_vld   (link_vld[PREV]),
            .link_in_data  (link_data[PREV]),
            .host_we       (host_we),
            .host_addr     (wr_addr),
            .host_data     (wr_data),
            .rd_addr       (rd_addr),
            .link_out_vld  (link_vld[k]),
            .link_out_data (link_data[k]),
            .rd_data       (node_rd[k])
        );
    end

    // Host read mux across cores.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NCORES; k++) begin
            if (rd_core == CW'(k)) rd_data = node_rd[k];
        end
    end

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/test_ring_collective.sv
`timescale 1ns/1ps
module test_ring_collective;
    localparam int N = 8;
    localparam int L = 4;
    localparam int W = 16;
    localparam int D = N * L;
    localparam int RUN_EDGES = (N - 1) * L + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         mode = 1'b0;
    logic         busy;
    logic         done;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_core = '0;
    logic [4:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   rd_core = '0;
    logic [4:0]   rd_addr = '0;
    logic [W-1:0] rd_data;

    int checks = 0;
    int fails = 0;

    logic [W-1:0] cur [N][D];
    logic [W-1:0] nxt [N][D];

    always #2 clk = ~clk;

    ring_collective #(.NCORES(N), .BLK_LEN(L), .WORD_W(W)) i_ring_collective (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .busy(busy), .done(done),
        .wr_en(wr_en), .wr_core(wr_core), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_core(rd_core), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Fill every buffer through the host port; pattern selects the values.
    task automatic load_all(int pat);
        for (int k = 0; k < N; k++) begin
            for (int a = 0; a < D; a++) begin
                logic [W-1:0] v;
                case (pat)
                    0: v = W'(k * 256 + a);
                    1: v = W'(16'hF000 + k * 16'h0111 + a * 7);
                    default: v = W'((k * 37 + a * 91) ^ 16'h5A5A);
                endcase
                @(negedge clk);
                wr_en = 1'b1; wr_core = 3'(k); wr_addr = 5'(a); wr_data = v;
                cur[k][a] = v;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Compare every buffer word with cur; own blocks and other blocks tagged apart.
    task automatic check_buffers(string req_own, string req_other);
        for (int k = 0; k < N; k++) begin
            for (int a = 0; a < D; a++) begin
                rd_core = 3'(k); rd_addr = 5'(a);
                #0.1;
                check((a / L == k) ? req_own : req_other,
                      $sformatf("core %0d addr %0d", k, a), int'(rd_data), int'(cur[k][a]));
            end
        end
    endtask

    // Closed-form expectation of a gather run on cur.
    task automatic model_gather();
        for (int k = 0; k < N; k++)
            for (int a = 0; a < D; a++)
                nxt[k][a] = cur[a / L][a];
        cur = nxt;
    endtask

    // Closed-form expectation of a reduce run: ring partial sums j+1..k.
    task automatic model_reduce();
        for (int k = 0; k < N; k++) begin
            for (int a = 0; a < D; a++) begin
                int j = a / L;
                int cnt = (k - j + N) % N;
                logic [W-1:0] s = '0;
                if (cnt == 0) cnt = N;
                for (int t = 0; t < cnt; t++) s = s + cur[(j + 1 + t) % N][a];
                nxt[k][a] = s;
            end
        end
        cur = nxt;
    endtask

    // Launch one run and check its timing. Optional disturbance mid-run.
    task automatic run_op(logic m, bit chained, bit poke_start, bit poke_write, bit pulse_chk);
        int n = 0;
        int busy_low = 0;
        if (!chained) @(negedge clk);
        start = 1'b1; mode = m;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R6", "busy after start", int'(busy), 1);
        while (n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0; wr_en = 1'b0;
            if (done) break;
            if (!busy) busy_low++;
            if (poke_start && n == 3) begin start = 1'b1; mode = ~m; end
            if (poke_write && n == 6) begin
                wr_en = 1'b1; wr_core = 3'd3; wr_addr = 5'd5; wr_data = 16'hDEAD;
            end
        end
        check(poke_start ? "R7" : "R6", "done edge count", n, RUN_EDGES);
        check("R6", "busy low before done", busy_low, 0);
        if (m) model_reduce(); else model_gather();
        if (pulse_chk) begin
            @(posedge clk);
            @(negedge clk);
            check("R6", "done pulse width", int'(done), 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "done after reset", int'(done), 0);
    endtask

    task automatic t_host_rw();
        load_all(0);
        check_buffers("R2", "R2");
    endtask

    task automatic t_gather();
        load_all(2);
        run_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check_buffers("R3", "R3");
    endtask

    task automatic t_reduce();
        load_all(0);
        run_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        check_buffers("R4", "R9");
    endtask

    task automatic t_wrap();
        load_all(1);
        run_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check_buffers("R5", "R5");
    endtask

    task automatic t_start_ignored();
        load_all(2);
        run_op(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        check_buffers("R7", "R7");
    endtask

    task automatic t_write_ignored();
        load_all(0);
        run_op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check_buffers("R8", "R8");
    endtask

    task automatic t_back_to_back();
        load_all(1);
        run_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_op(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        check_buffers("R10", "R10");
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_host_rw();
        t_gather();
        t_reduce();
        t_wrap();
        t_start_ignored();
        t_write_ignored();
        t_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule